// File: doc/BRIEF.md
# Power and Mode Override Controller

This block works out the operating state of a mixed-signal receiver chip from three sources. The first is a serial control word, given here as parallel bits. The second is a hard shutdown pin. The third is a mode pin with three levels. From these it drives one enable per power domain and the effective values of three configuration selects: oscillator select, divider-bank select and input select.

Power is resolved in a fixed order of priority. The shutdown pin turns everything off, including the serial interface. A cleared run bit in the control word turns everything off except the serial interface, so the chip can still be woken through its port. A cleared awake bit gates only the gain-stage and demodulator domains. The mode pin acts on the selects and on nothing else. Driven high or low, it forces all three selects to that level. Left floating, it hands each select back to its own register bit.

All outputs are registered on the system clock. A synchronous reset puts the block into full shutdown.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `pin_shdn` is 1, every bit of `pwr_en` is 0, including bit 0 (serial interface), whatever the register bits are.
- R2: With `pin_shdn` 0 and `reg_run` 0, `pwr_en` is 5'b00001: only bit 0, the serial interface, stays enabled.
- R3: With `pin_shdn` 0, `reg_run` 1 and `reg_awake` 0, `pwr_en` is 5'b11001. Bit 1 (gain stage) and bit 2 (demodulator) are off. Bit 0 (serial), bit 3 (synthesizer) and bit 4 (oscillator) stay on.
- R4: With `pin_shdn` 0, `reg_run` 1 and `reg_awake` 1, `pwr_en` is 5'b11111.
- R5: A mode code of 2'b01 (pin driven high) forces every bit of `sel_eff` to 1. The bits are: bit 0 oscillator, bit 1 divider bank, bit 2 input.
- R6: A mode code of 2'b00 (pin driven low) forces every bit of `sel_eff` to 0.
- R7: A mode code with bit 1 set (2'b10 or 2'b11, pin floating) makes each bit of `sel_eff` equal the same bit of `reg_sel`.
- R8: The value of `sel_eff` does not depend on `pin_shdn`, `reg_run` or `reg_awake`.
- R9: A clock edge with `rst` 1 sets `pwr_en` to 0 and `sel_eff` to 0.
- R10: The shutdown pin takes priority over a cleared run bit, and a cleared run bit takes priority over a cleared awake bit.
- R11: An input change shows at the outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_shdn | input | 1 | Hard shutdown pin, 1 = shut down |
| pin_mode | input | 2 | Mode pin code: 00 low, 01 high, 1x floating |
| reg_run | input | 1 | Register run bit, 0 = chip off except serial port |
| reg_awake | input | 1 | Register awake bit, 0 = gain stage and demodulator off |
| reg_sel | input | N_SEL | Register select bits (oscillator, divider bank, input) |
| pwr_en | output | 5 | Domain enables: serial, gain stage, demodulator, synthesizer, oscillator |
| sel_eff | output | N_SEL | Effective select lines after the mode override |

## Verification
Suppose the decoded power level were wrong. The very next registered value of `pwr_en` would show a pattern that does not match the input combination. The most telling case is the serial enable: it must differ between a pin shutdown and a register shutdown. A fault in the override path would show up as a select that either ignores its register bit while the pin floats, or follows its register bit while the pin is driven. This also shows one clock after the change. Since nothing is stored beyond the output stage, every fault is visible within one cycle, and stimulus held for two cycles is enough to expose it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int DOM_N     = 5;
  localparam int DOM_PORT  = 0;
  localparam int DOM_VGA   = 1;
  localparam int DOM_DEMOD = 2;
  localparam int DOM_SYNTH = 3;
  localparam int DOM_VCO   = 4;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'd0,
    LVL_PORT = 2'd1,
    LVL_STBY = 2'd2,
    LVL_RUN  = 2'd3
  } lvl_t;

  typedef logic [DOM_N-1:0] dom_vec_t;

  // Priority: pin shutdown, then register run bit, then awake bit (R10).
  function automatic lvl_t resolve_level(input logic pin_off,
                                         input logic run,
                                         input logic awake);
    lvl_t l;
    if (pin_off)     l = LVL_OFF;
    else if (!run)   l = LVL_PORT;
    else if (!awake) l = LVL_STBY;
    else             l = LVL_RUN;
    return l;
  endfunction

  function automatic dom_vec_t domain_mask(input lvl_t l);
    dom_vec_t m;
    m = '0;
    case (l)
      LVL_OFF:  m = '0;
      LVL_PORT: m[DOM_PORT] = 1'b1;
      LVL_STBY: begin
        m = '1;
        m[DOM_VGA]   = 1'b0;
        m[DOM_DEMOD] = 1'b0;
      end
      default:  m = '1;
    endcase
    return m;
  endfunction

  function automatic logic mode_floats(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic pick_sel(input logic [1:0] code, input logic reg_bit);
    logic v;
    if (mode_floats(code)) v = reg_bit;
    else                   v = code[0];
    return v;
  endfunction

endpackage

// File: rtl/pmc_level.sv
module pmc_level
  import pmc_pkg::*;
(
  input  logic     pin_off,
  input  logic     run,
  input  logic     awake,
  output lvl_t     lvl,
  output dom_vec_t mask
);

  lvl_t lvl_c;

  always_comb begin
    lvl_c = resolve_level(pin_off, run, awake);
  end

  assign lvl  = lvl_c;
  assign mask = domain_mask(lvl_c);

endmodule

// File: rtl/pmc_sel_ovr.sv
module pmc_sel_ovr
  import pmc_pkg::*;
#(
  parameter int N_SEL = 3
) (
  input  logic [1:0]       code,
  input  logic [N_SEL-1:0] reg_bits,
  output logic             driven,
  output logic [N_SEL-1:0] sel
);

  assign driven = ~mode_floats(code);

  for (genvar g = 0; g < N_SEL; g++) begin : g_bit
    assign sel[g] = pick_sel(code, reg_bits[g]);
  end

endmodule

// File: rtl/pmc_out_reg.sv
module pmc_out_reg #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_SEL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_shdn,
  input  logic [1:0]       pin_mode,
  input  logic             reg_run,
  input  logic             reg_awake,
  input  logic [N_SEL-1:0] reg_sel,
  output logic [DOM_N-1:0] pwr_en,
  output logic [N_SEL-1:0] sel_eff
);

  localparam int W_OUT = DOM_N + N_SEL;

  lvl_t             lvl_w;
  dom_vec_t         mask_w;
  logic             ovr_active;
  logic [N_SEL-1:0] sel_w;
  logic [W_OUT-1:0] out_d;
  logic [W_OUT-1:0] out_q;

  pmc_level u_level (
    .pin_off (pin_shdn),
    .run     (reg_run),
    .awake   (reg_awake),
    .lvl     (lvl_w),
    .mask    (mask_w)
  );

  pmc_sel_ovr #(.N_SEL(N_SEL)) u_ovr (
    .code     (pin_mode),
    .reg_bits (reg_sel),
    .driven   (ovr_active),
    .sel      (sel_w)
  );

  assign out_d = {sel_w, mask_w};

  pmc_out_reg #(.W(W_OUT), .RST_VAL('0)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign pwr_en  = out_q[DOM_N-1:0];
  assign sel_eff = out_q[W_OUT-1:DOM_N];

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pmc_pkg::*;
#(
  parameter int N_SEL = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             pin_shdn,
  input logic [1:0]       pin_mode,
  input logic             reg_run,
  input logic             reg_awake,
  input logic [N_SEL-1:0] reg_sel,
  input logic [DOM_N-1:0] pwr_en,
  input logic [N_SEL-1:0] sel_eff,
  input lvl_t             lvl_w,
  input logic             ovr_active
);

  a_r1_pin_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_shdn)) |-> (pwr_en == '0));

  a_r2_port_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pin_shdn) && !$past(reg_run)) |-> (pwr_en == 5'b00001));

  a_r3_standby: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pin_shdn) && $past(reg_run) && !$past(reg_awake))
      |-> (pwr_en == 5'b11001));

  a_r4_full_run: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pin_shdn) && $past(reg_run) && $past(reg_awake))
      |-> (pwr_en == 5'b11111));

  a_r5_mode_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_mode) == 2'b01) |-> (sel_eff == '1));

  a_r6_mode_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_mode) == 2'b00) |-> (sel_eff == '0));

  a_r7_float: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_mode[1])) |-> (sel_eff == $past(reg_sel)));

  a_r8_sel_in_shdn: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pin_shdn) && $past(pin_mode) == 2'b01) |-> (sel_eff == '1));

  a_r9_reset: assert property (@(posedge clk)
    $past(rst) |-> (pwr_en == '0 && sel_eff == '0));

  a_r10_pin_wins: assert property (@(posedge clk) disable iff (rst)
    pin_shdn |-> (lvl_w == LVL_OFF));

  a_r7_ovr_flag: assert property (@(posedge clk) disable iff (rst)
    ovr_active |-> !pin_mode[1]);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_SEL(N_SEL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pin_shdn   (pin_shdn),
  .pin_mode   (pin_mode),
  .reg_run    (reg_run),
  .reg_awake  (reg_awake),
  .reg_sel    (reg_sel),
  .pwr_en     (pwr_en),
  .sel_eff    (sel_eff),
  .lvl_w      (lvl_w),
  .ovr_active (ovr_active)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_shdn = 1'b0;
  logic [1:0] pin_mode = 2'b10;
  logic       reg_run = 1'b1;
  logic       reg_awake = 1'b1;
  logic [2:0] reg_sel = 3'b000;
  logic [4:0] pwr_en;
  logic [2:0] sel_eff;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_SEL(3)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .pin_shdn  (pin_shdn),
    .pin_mode  (pin_mode),
    .reg_run   (reg_run),
    .reg_awake (reg_awake),
    .reg_sel   (reg_sel),
    .pwr_en    (pwr_en),
    .sel_eff   (sel_eff)
  );

  // Expected domain enables, bit0 serial .. bit4 oscillator.
  function automatic logic [4:0] exp_en(input logic p, input logic r, input logic a);
    if (p)       return 5'b00000;
    if (!r)      return 5'b00001;
    if (!a)      return 5'b11001;
    return 5'b11111;
  endfunction

  function automatic logic [2:0] exp_sel(input logic [1:0] m, input logic [2:0] rs);
    if (m == 2'b00) return 3'b000;
    if (m == 2'b01) return 3'b111;
    return rs;
  endfunction

  task automatic chk_en(input string req, input logic [4:0] exp);
    n_chk++;
    if (pwr_en !== exp) begin
      n_fail++;
      $display("FAIL %s pwr_en actual=%b expected=%b", req, pwr_en, exp);
    end
  endtask

  task automatic chk_sel(input string req, input logic [2:0] exp);
    n_chk++;
    if (sel_eff !== exp) begin
      n_fail++;
      $display("FAIL %s sel_eff actual=%b expected=%b", req, sel_eff, exp);
    end
  endtask

  task automatic apply(input logic p, input logic [1:0] m, input logic r,
                       input logic a, input logic [2:0] rs);
    @(negedge clk);
    pin_shdn = p; pin_mode = m; reg_run = r; reg_awake = a; reg_sel = rs;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_en("R9", 5'b00000);
    chk_sel("R9", 3'b000);
  endtask

  task automatic t_power_levels;
    apply(1, 2'b10, 1, 1, 3'b000); chk_en("R1", 5'b00000);
    apply(0, 2'b10, 0, 1, 3'b000); chk_en("R2", 5'b00001);
    apply(0, 2'b10, 1, 0, 3'b000); chk_en("R3", 5'b11001);
    apply(0, 2'b10, 1, 1, 3'b000); chk_en("R4", 5'b11111);
  endtask

  task automatic t_priority;
    apply(1, 2'b10, 0, 0, 3'b000); chk_en("R10", 5'b00000);
    apply(0, 2'b10, 0, 0, 3'b000); chk_en("R10", 5'b00001);
    apply(1, 2'b10, 0, 1, 3'b000); chk_en("R10", 5'b00000);
  endtask

  task automatic t_mode_pin;
    apply(0, 2'b01, 1, 1, 3'b000); chk_sel("R5", 3'b111);
    apply(0, 2'b01, 1, 1, 3'b010); chk_sel("R5", 3'b111);
    apply(0, 2'b00, 1, 1, 3'b111); chk_sel("R6", 3'b000);
    apply(0, 2'b00, 1, 1, 3'b101); chk_sel("R6", 3'b000);
    apply(0, 2'b10, 1, 1, 3'b101); chk_sel("R7", 3'b101);
    apply(0, 2'b11, 1, 1, 3'b010); chk_sel("R7", 3'b010);
    for (int v = 0; v < 8; v++) begin
      apply(0, 2'b10, 1, 1, 3'(v)); chk_sel("R7", 3'(v));
    end
  endtask

  task automatic t_sel_independent;
    apply(1, 2'b01, 0, 0, 3'b000); chk_sel("R8", 3'b111);
    apply(0, 2'b10, 0, 1, 3'b110); chk_sel("R8", 3'b110);
    apply(0, 2'b00, 1, 0, 3'b111); chk_sel("R8", 3'b000);
    chk_en("R8", 5'b11001);
  endtask

  task automatic t_latency;
    apply(0, 2'b10, 1, 1, 3'b011);
    @(negedge clk);
    pin_shdn = 1; pin_mode = 2'b00;
    #2;
    chk_en("R11", 5'b11111);
    chk_sel("R11", 3'b011);
    @(posedge clk); #1;
    chk_en("R11", exp_en(1, 1, 1));
    chk_sel("R11", exp_sel(2'b00, 3'b011));
  endtask

  task automatic t_mid_reset;
    apply(0, 2'b01, 1, 1, 3'b000);
    chk_en("R4", 5'b11111);
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk);
    chk_en("R9", 5'b00000);
    chk_sel("R9", 3'b000);
    rst = 0;
    @(posedge clk); @(negedge clk);
    chk_en("R9", 5'b11111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst = 0;
    t_power_levels;
    t_priority;
    t_mode_pin;
    t_sel_independent;
    t_latency;
    t_mid_reset;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule